// File: doc/BRIEF.md
# Successive-Approximation A-D Conversion Controller

This block is the digital half of a byte-register A-D converter peripheral. Software programs a control byte that picks one of eight analog inputs, a conversion clock divisor, the resolution and a booster flag. It then launches a conversion by writing that byte with its completion bit cleared. The block drives a channel select and a trial code to an external comparator. Once per conversion-clock period it takes back a single greater-or-equal answer, and it resolves the result one bit at a time, most significant bit first.

When the conversion ends, the result is readable as two bytes. The upper eight bits sit in one register. The two lowest bits sit at the top of a second register, which also carries a switch that keeps the reference ladder powered between conversions. Completion sets the status bit and emits a one-cycle interrupt pulse. A stop-mode input cuts a running conversion short and reports it as complete.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Control bits 2..0 hold the channel number (000 = channel 0 up to 111 = channel 7). The number drives `chan_sel` and reads back unchanged.
- R2: Writing the control register with bit 3 = 0 starts a conversion. Bit 3 reads 0 while a conversion runs and 1 otherwise, including after reset, where the control byte reads 0x08.
- R3: Control bits 5..4 set the step length to 2, 4, 8 or 16 clock cycles for codes 00, 01, 10 and 11. From the clock edge that takes the start write, completion is visible exactly steps × step-length edges later.
- R4: Control bit 6 = 0 gives a 10-step conversion. Bit 6 = 1 gives 8 steps, puts the 8-bit result in the high register, keeps the two lowest trial-code bits at 0 and reads result-low bits 7..6 as 0.
- R5: Register 1 (result high) returns result bits 9..2. Register 2 (result low) returns result bits 1..0 in its bits 7..6, and bits 5..0 read 0.
- R6: Control bit 7 (booster) is stored and read back, and has no effect on timing or result.
- R7: Bit 0 of register 2 is a ladder switch. When it is 1, `ladder_en` stays 1. When it is 0, `ladder_en` is 1 only while a conversion runs.
- R8: Each finished conversion raises `adc_irq` for exactly one cycle, in the cycle where bit 3 first reads 1 again.
- R9: `abort_stop` during a conversion ends it at the next edge, with bit 3 = 1, one `adc_irq` pulse and only the bits resolved so far kept. When idle, `abort_stop` has no effect.
- R10: Writes to register 1 are ignored.
- R11: During a step, `dac_code` equals the bits kept so far plus the bit under test. That bit is kept when `cmp_ge` = 1 (input at or above the trial level), so the final result is the largest code not above the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register select: 0 control, 1 result high, 2 result low / ladder switch |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| abort_stop | input | 1 | Stop-mode entry; aborts a running conversion |
| cmp_ge | input | 1 | Comparator answer: selected input ≥ trial level |
| chan_sel | output | 3 | Analog channel select |
| dac_code | output | 10 | Trial code for the comparison ladder |
| ladder_en | output | 1 | Reference ladder connect |
| adc_irq | output | 1 | One-cycle completion interrupt |

## Verification
The assertions assume that software does not rewrite the resolution or divisor fields while a conversion is running. They also assume `cmp_ge` settles within the same cycle from `dac_code` and the selected channel. The bench models the comparator as a combinational compare of a per-channel 10-bit value against `dac_code`. It writes the control register only when bit 3 reads 1, except in the deliberate abort case, and holds `abort_stop` for a single cycle.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int RES_W   = 10;
  localparam int SHORT_W = 8;
  localparam int CH_W    = 3;
  localparam int DIV_W   = 2;
  localparam int BYTE_W  = 8;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RES_HI = 2'd1;
  localparam logic [1:0] ADDR_RES_LO = 2'd2;

  // fixed bit positions of the control byte
  localparam int CTL_DONE  = 3;
  localparam int CTL_DIV   = 4;
  localparam int CTL_SHORT = 6;
  localparam int CTL_BOOST = 7;
endpackage

// File: rtl/sar_adc_prescaler.sv
module sar_adc_prescaler #(
  parameter int DIV_W = sar_adc_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int CNT_W = 1 << DIV_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic [DIV_W:0]   shamt;

  always_comb begin
    shamt = {1'b0, div_sel} + 1'b1;
    limit = ~({CNT_W{1'b1}} << shamt);
    tick  = run && (cnt_q == limit);
    if (!run || restart || tick) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int RES_W   = sar_adc_pkg::RES_W,
  parameter int SHORT_W = sar_adc_pkg::SHORT_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp,
  input  logic             short_mode,
  output logic             busy,
  output logic [RES_W-1:0] sar,
  output logic [RES_W-1:0] dac_code,
  output logic             irq
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] TOP_IDX    = IDX_W'(RES_W - 1);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(RES_W - SHORT_W);

  logic             busy_q, busy_d, irq_q, irq_d;
  logic [RES_W-1:0] sar_q, sar_d, trial;
  logic [IDX_W-1:0] idx_q, idx_d, last_idx;

  always_comb begin
    last_idx = short_mode ? SHORT_LAST : '0;
    trial    = RES_W'(1) << idx_q;
    busy_d   = busy_q;
    sar_d    = sar_q;
    idx_d    = idx_q;
    irq_d    = 1'b0;
    if (abort && busy_q) begin
      busy_d = 1'b0;
      irq_d  = 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      sar_d  = '0;
      idx_d  = TOP_IDX;
    end else if (busy_q && tick) begin
      if (cmp) sar_d = sar_q | trial;
      if (idx_q == last_idx) begin
        busy_d = 1'b0;
        irq_d  = 1'b1;
      end else begin
        idx_d = idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sar_q  <= '0;
      idx_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sar_q  <= sar_d;
      idx_q  <= idx_d;
      irq_q  <= irq_d;
    end
  end

  assign busy     = busy_q;
  assign sar      = sar_q;
  assign irq      = irq_q;
  assign dac_code = busy_q ? (sar_q | trial) : sar_q;
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
  import sar_adc_pkg::*;
#(
  parameter int RES_W = sar_adc_pkg::RES_W,
  parameter int CH_W  = sar_adc_pkg::CH_W,
  parameter int DIV_W = sar_adc_pkg::DIV_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              busy,
  input  logic [RES_W-1:0]  result,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              start,
  output logic [CH_W-1:0]   chan,
  output logic [DIV_W-1:0]  div_sel,
  output logic              short_mode,
  output logic              ladder_sw
);
  localparam int LO_W = RES_W - BYTE_W;

  logic             ctrl_we, lo_we, boost_q;
  logic [CH_W-1:0]  chan_q;
  logic [DIV_W-1:0] div_q;
  logic             short_q, ladder_q;

  assign ctrl_we = bus_wr && (bus_addr == ADDR_CTRL);
  assign lo_we   = bus_wr && (bus_addr == ADDR_RES_LO);
  assign start   = ctrl_we && !bus_wdata[CTL_DONE];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q   <= '0;
      div_q    <= '0;
      short_q  <= 1'b0;
      boost_q  <= 1'b0;
      ladder_q <= 1'b0;
    end else begin
      if (ctrl_we) begin
        chan_q  <= bus_wdata[CH_W-1:0];
        div_q   <= bus_wdata[CTL_DIV +: DIV_W];
        short_q <= bus_wdata[CTL_SHORT];
        boost_q <= bus_wdata[CTL_BOOST];
      end
      if (lo_we) ladder_q <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: begin
        bus_rdata[CH_W-1:0]          = chan_q;
        bus_rdata[CTL_DONE]          = !busy;
        bus_rdata[CTL_DIV +: DIV_W]  = div_q;
        bus_rdata[CTL_SHORT]         = short_q;
        bus_rdata[CTL_BOOST]         = boost_q;
      end
      ADDR_RES_HI: bus_rdata = result[RES_W-1 -: BYTE_W];
      ADDR_RES_LO: bus_rdata[BYTE_W-1 -: LO_W] = short_q ? '0 : result[LO_W-1:0];
      default:     bus_rdata = '0;
    endcase
  end

  assign chan       = chan_q;
  assign div_sel    = div_q;
  assign short_mode = short_q;
  assign ladder_sw  = ladder_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              abort_stop,
  input  logic              cmp_ge,
  output logic [CH_W-1:0]   chan_sel,
  output logic [RES_W-1:0]  dac_code,
  output logic              ladder_en,
  output logic              adc_irq
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             busy, start, tick, short_mode, ladder_sw;
  logic [DIV_W-1:0] div_sel;
  logic [RES_W-1:0] sar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sar_adc_regs #(.RES_W(RES_W), .CH_W(CH_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_ni(rst_sync_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .result(sar), .bus_rdata(bus_rdata),
    .start(start), .chan(chan_sel), .div_sel(div_sel),
    .short_mode(short_mode), .ladder_sw(ladder_sw)
  );

  sar_adc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_ni(rst_sync_n), .run(busy), .restart(start),
    .div_sel(div_sel), .tick(tick)
  );

  sar_adc_seq #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_seq (
    .clk(clk), .rst_ni(rst_sync_n), .start(start), .abort(abort_stop),
    .tick(tick), .cmp(cmp_ge), .short_mode(short_mode), .busy(busy),
    .sar(sar), .dac_code(dac_code), .irq(adc_irq)
  );

  assign ladder_en = ladder_sw | busy;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int RES_W = sar_adc_pkg::RES_W
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             busy,
  input logic             tick,
  input logic             start,
  input logic             abort,
  input logic             short_mode,
  input logic [RES_W-1:0] dac_code,
  input logic [RES_W-1:0] sar,
  input logic             ladder_en,
  input logic             irq
);
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |=> !irq);

  a_r8_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> $past(busy));

  a_r9_abort_ends: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && abort) |=> (!busy && irq));

  a_r7_ladder_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> ladder_en);

  a_r4_short_lsbs: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && short_mode) |-> (dac_code[1:0] == 2'b00));

  a_r11_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !tick && !abort && !start) |=> $stable(sar));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk u_chk (
  .clk(clk), .rst_ni(rst_sync_n), .busy(busy), .tick(tick), .start(start),
  .abort(abort_stop), .short_mode(short_mode), .dac_code(dac_code),
  .sar(sar), .ladder_en(ladder_en), .irq(adc_irq)
);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       abort_stop = 1'b0;
  logic       cmp_ge;
  logic [2:0] chan_sel;
  logic [9:0] dac_code;
  logic       ladder_en;
  logic       adc_irq;
  logic [9:0] vin [8];

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign cmp_ge = (vin[chan_sel] >= dac_code);

  sar_adc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .abort_stop(abort_stop),
    .cmp_ge(cmp_ge), .chan_sel(chan_sel), .dac_code(dac_code),
    .ladder_en(ladder_en), .adc_irq(adc_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // waits until bit 3 reads 1; returns edges counted after the start edge
  task automatic wait_done(output int c);
    logic [7:0] d;
    c = 0;
    rd(2'd0, d);
    while (!d[3] && c < 1000) begin
      @(negedge clk);
      c++;
      rd(2'd0, d);
    end
  endtask

  task automatic convert(input int ch, input int dv, input bit sm, input bit bst, input int val);
    int c, steps, expc;
    logic [7:0] d, ctl;
    vin[ch] = 10'(val);
    ctl = {bst, sm, 2'(dv), 1'b0, 3'(ch)};
    wr(2'd0, ctl);
    wait_done(c);
    steps = sm ? 8 : 10;
    expc  = steps * (2 << dv);
    check(c == expc, "R3 conversion length", c, expc);
    check(adc_irq == 1'b1, "R8 irq at completion", adc_irq, 1);
    rd(2'd0, d);
    check(d == (ctl | 8'h08), "R1/R2/R6 control readback", d, ctl | 8'h08);
    check(chan_sel == 3'(ch), "R1 chan_sel", chan_sel, ch);
    rd(2'd1, d);
    check(d == 8'(val >> 2), "R5/R11 result high", d, val >> 2);
    rd(2'd2, d);
    if (sm) check(d == 8'h00, "R4 short-mode low bits", d, 0);
    else    check(d == {2'(val), 6'b0}, "R5 result low", d, {2'(val), 6'b0});
    @(negedge clk);
    check(adc_irq == 1'b0, "R8 irq one cycle", adc_irq, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d, hi0;
    int c, irqs;
    for (int i = 0; i < 8; i++) vin[i] = 10'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(2'd0, d); check(d == 8'h08, "R2 reset control", d, 8'h08);
    rd(2'd1, d); check(d == 8'h00, "R5 reset high", d, 0);
    rd(2'd2, d); check(d == 8'h00, "R5 reset low", d, 0);
    check(ladder_en == 1'b0, "R7 ladder off at reset", ladder_en, 0);
    check(adc_irq == 1'b0, "R8 no irq at reset", adc_irq, 0);

    // trial codes of a single conversion, slowest clock
    vin[2] = 10'h2A5;
    wr(2'd0, 8'h32);
    check(dac_code == 10'h200, "R11 first trial", dac_code, 10'h200);
    check(ladder_en == 1'b1, "R7 ladder on while busy", ladder_en, 1);
    rd(2'd0, d); check(d[3] == 1'b0, "R2 busy reads 0", d[3], 0);
    repeat (16) @(negedge clk);
    check(dac_code == 10'h300, "R11 second trial after keep", dac_code, 10'h300);
    repeat (16) @(negedge clk);
    check(dac_code == 10'h280, "R11 third trial after drop", dac_code, 10'h280);
    wait_done(c);
    rd(2'd1, d); check(d == 8'hA9, "R11 final high", d, 8'hA9);
    rd(2'd2, d); check(d == 8'h40, "R11 final low", d, 8'h40);
    @(negedge clk);
    check(ladder_en == 1'b0, "R7 ladder off when idle", ladder_en, 0);

    // sweep of divisor, resolution, channel
    for (int dv = 0; dv < 4; dv++)
      for (int sm = 0; sm < 2; sm++)
        for (int ch = 0; ch < 8; ch++) begin
          int val;
          val = (ch == 0) ? 0 : (ch == 7) ? 1023 : (ch == 3) ? 512 : (ch == 4) ? 511
              : (ch * 131 + dv * 257 + sm * 61 + 7) % 1024;
          convert(ch, dv, sm[0], dv[0], val);
        end

    // writes to result high ignored
    rd(2'd1, hi0);
    wr(2'd1, 8'h5A);
    rd(2'd1, d); check(d == hi0, "R10 high write ignored", d, hi0);

    // ladder switch
    wr(2'd2, 8'h01);
    check(ladder_en == 1'b1, "R7 ladder forced on", ladder_en, 1);
    rd(2'd2, d); check((d & 8'h3F) == 8'h00, "R5 low bits 5..0 read 0", d & 8'h3F, 0);
    wr(2'd2, 8'h00);
    check(ladder_en == 1'b0, "R7 ladder released", ladder_en, 0);

    // abort during conversion
    vin[5] = 10'h3FF;
    wr(2'd0, 8'h35);
    repeat (20) @(negedge clk);
    abort_stop = 1'b1;
    @(negedge clk);
    abort_stop = 1'b0;
    rd(2'd0, d); check(d[3] == 1'b1, "R9 abort sets done", d[3], 1);
    check(adc_irq == 1'b1, "R9 abort irq", adc_irq, 1);
    rd(2'd1, d); check(d == 8'h80, "R9 partial result high", d, 8'h80);
    rd(2'd2, d); check(d == 8'h00, "R9 partial result low", d, 0);
    irqs = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (adc_irq) irqs++;
    end
    check(irqs == 0, "R9 no later completion", irqs, 0);

    // abort while idle
    abort_stop = 1'b1;
    @(negedge clk);
    abort_stop = 1'b0;
    check(adc_irq == 1'b0, "R9 idle abort no irq", adc_irq, 0);
    rd(2'd0, d); check(d[3] == 1'b1, "R9 idle abort done stays", d[3], 1);
    rd(2'd1, d); check(d == 8'h80, "R9 idle abort result kept", d, 8'h80);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule